// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Read Option

This block is a first-in first-out store whose write port and read port run on unrelated clocks. Words of `WIDTH` bits (18 by default) are written on `wclk` and read on `rclk`. The memory holds 2^`ADDR_W` words (D, 32 by default). Pointers cross between the two clock domains in Gray code through multi-flop synchronisers. Every flag on the write side is computed from the synchronised read pointer. Every flag on the read side is computed from the synchronised write pointer.

The `fwft_mode` input is static and is only changed while reset is held. It selects one of two read behaviours. In standard mode, `rdy_n` is an active-low empty flag, and a word reaches `rd_data` only after a read request. In fall-through mode, the same pin is an active-low output-ready flag. The oldest word moves to `rd_data` without any request, and a read request consumes it. Because the output register holds one extra word in fall-through mode, the capacity and every flag threshold move up by one.

The block also drives three active-low flags: programmable almost-full, programmable almost-empty and half-full. The full offset m and the empty offset n are input ports. They are captured once, right after reset is released.

Top module: `twin_clock_queue`

## Requirements
- R1: Words leave in the order they were accepted, and no accepted word is lost or duplicated, even when writes and reads run at the same time on both clocks.
- R2: In standard mode (`fwft_mode`=0), `rdy_n` is 1 while at least one word is stored and 0 when the store is empty. A read request made while `rdy_n` is 0 is ignored, and `rd_data` keeps its previous value.
- R3: In fall-through mode (`fwft_mode`=1), `rdy_n` goes to 0 once the oldest word is present on `rd_data`, with no read request. Each read consumes that word. After the last word is consumed, `rdy_n` returns to 1, `rd_data` keeps the last word, and further reads change nothing.
- R4: `afull_n` is 0 when the words held reach D−m in standard mode or D+1−m in fall-through mode. The held count includes the output word in fall-through mode. The flag is never driven to 0 by a `wclk` edge without a write request.
- R5: `aempty_n` is 0 when the words held are n or fewer in standard mode, or n+1 or fewer in fall-through mode. The flag never falls on an `rclk` edge without a read request.
- R6: `hfull_n` goes to 0 after D/2+1 held words in standard mode and after D/2+2 in fall-through mode. It is set by a `wclk` edge carrying a write. It returns to 1 once reads bring the count back to the threshold minus one, after the read pointer has crossed to the write domain.
- R7: The capacity is D words in standard mode and D+1 in fall-through mode. Writes beyond the capacity are dropped, and the stored memory count never exceeds D.
- R8: While `rst_n` is 0, `rdy_n`=1, `aempty_n`=0, `afull_n`=1 and `hfull_n`=1. After release in standard mode, `rdy_n` settles to 0.
- R9: `full_ofs` and `empty_ofs` are sampled on the first clock edge after reset release in each domain. Later changes on those ports do not move the thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| fwft_mode | input | 1 | 0 selects standard reads, 1 selects fall-through reads |
| wr_en | input | 1 | Write request, sampled on `wclk` |
| wr_data | input | WIDTH | Word to store |
| full_ofs | input | ADDR_W+1 | Almost-full offset m, captured after reset |
| rd_en | input | 1 | Read request, sampled on `rclk` |
| empty_ofs | input | ADDR_W+1 | Almost-empty offset n, captured after reset |
| rd_data | output | WIDTH | Word read out |
| rdy_n | output | 1 | Empty flag in standard mode, output-ready flag in fall-through mode (both active low) |
| afull_n | output | 1 | Programmable almost-full flag, active low, on `wclk` |
| aempty_n | output | 1 | Programmable almost-empty flag, active low, on `rclk` |
| hfull_n | output | 1 | Half-full flag, active low |

## Verification
The pair that overlaps is a write landing on `wclk` and a read consuming a word on `rclk` in the same stretch of time. In fall-through mode this includes the case where a newly synchronised word is loaded into the output register on the same edge that a read empties it. To provoke this, a writer and a reader run concurrently on clocks of 20 and 26 time units, with the reader popping whenever a word is offered, in both modes. The result is judged by comparing every popped word with a queue model and by checking the quiet flag state afterwards.

// File: rtl/tcq_pkg.sv
package tcq_pkg;

  typedef enum logic {
    RD_STD  = 1'b0,
    RD_FWFT = 1'b1
  } rd_mode_e;

  function automatic logic [31:0] bin_to_gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray_to_bin(input logic [31:0] g);
    logic [31:0] b;
    for (int i = 0; i < 32; i++) b[i] = ^(g >> i);
    return b;
  endfunction

endpackage

// File: rtl/tcq_rst_sync.sv
module tcq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = chain_q[STAGES-1];
endmodule

// File: rtl/tcq_sync.sv
module tcq_sync #(
  parameter int W      = 6,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
    end else begin
      stage_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/tcq_wside.sv
module tcq_wside
  import tcq_pkg::*;
#(
  parameter int AW = 5,
  parameter int PW = AW + 1
) (
  input  logic          wclk,
  input  logic          srst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] rgray_s,
  input  logic [PW-1:0] full_ofs,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] used,
  output logic          afull_n,
  output logic          hfull_n
);
  localparam int            DEPTH   = 1 << AW;
  localparam logic [PW:0]   DEPTH_X = (PW+1)'(DEPTH);
  localparam logic [PW-1:0] HALF    = PW'(DEPTH / 2);

  logic [PW-1:0] wptr_q, wptr_d, rbin_s, used_d, mofs_q;
  logic          armed_q, full, af_d, hf_d;

  // next state
  always_comb begin
    rbin_s  = PW'(gray_to_bin(32'(rgray_s)));
    used    = wptr_q - rbin_s;
    full    = (used == PW'(DEPTH));
    wr_fire = wr_en & ~full;
    wptr_d  = wptr_q + PW'(wr_fire);
    used_d  = wptr_d - rbin_s;
    af_d    = (({1'b0, used_d} + {1'b0, mofs_q}) < DEPTH_X);
    hf_d    = (used_d <= HALF);
  end

  // registers
  always_ff @(posedge wclk or negedge srst_n) begin
    if (!srst_n) begin
      wptr_q  <= '0;
      wgray   <= '0;
      mofs_q  <= '0;
      armed_q <= 1'b0;
      afull_n <= 1'b1;
      hfull_n <= 1'b1;
    end else begin
      if (wr_fire) begin
        wptr_q <= wptr_d;
        wgray  <= PW'(bin_to_gray(32'(wptr_d)));
      end
      if (!armed_q) begin
        armed_q <= 1'b1;
        mofs_q  <= full_ofs;
      end
      afull_n <= af_d;
      hfull_n <= hf_d;
    end
  end

  assign waddr = wptr_q[AW-1:0];
endmodule

// File: rtl/tcq_rside.sv
module tcq_rside
  import tcq_pkg::*;
#(
  parameter int AW = 5,
  parameter int PW = AW + 1,
  parameter int W  = 18
) (
  input  logic          rclk,
  input  logic          srst_n,
  input  logic          fwft,
  input  logic          rd_en,
  input  logic [PW-1:0] wgray_s,
  input  logic [PW-1:0] empty_ofs,
  input  logic [W-1:0]  mem_q,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [W-1:0]  rd_data,
  output logic          rdy_n,
  output logic          aempty_n
);
  rd_mode_e      mode;
  logic [PW-1:0] rptr_q, rptr_d, wbin_s, avail, avail_d, nofs_q;
  logic [PW:0]   held_d, lim;
  logic          pop, ov, ov_d, flag_d, ae_d, armed_q;

  // next state
  always_comb begin
    mode   = fwft ? RD_FWFT : RD_STD;
    wbin_s = PW'(gray_to_bin(32'(wgray_s)));
    avail  = wbin_s - rptr_q;
    ov     = ~rdy_n;
    if (mode == RD_FWFT) begin
      pop  = (avail != '0) && (!ov || rd_en);
      ov_d = pop | (ov & ~rd_en);
    end else begin
      pop  = rd_en && rdy_n && (avail != '0);
      ov_d = 1'b0;
    end
    rptr_d  = rptr_q + PW'(pop);
    avail_d = avail - PW'(pop);
    flag_d  = (mode == RD_FWFT) ? ~ov_d : (avail_d != '0);
    held_d  = {1'b0, avail_d} + (PW+1)'(ov_d);
    lim     = {1'b0, nofs_q} + (PW+1)'(mode == RD_FWFT);
    ae_d    = (held_d > lim);
  end

  // registers
  always_ff @(posedge rclk or negedge srst_n) begin
    if (!srst_n) begin
      rptr_q   <= '0;
      rgray    <= '0;
      rd_data  <= '0;
      nofs_q   <= '0;
      armed_q  <= 1'b0;
      rdy_n    <= 1'b1;
      aempty_n <= 1'b0;
    end else begin
      if (pop) begin
        rptr_q  <= rptr_d;
        rgray   <= PW'(bin_to_gray(32'(rptr_d)));
        rd_data <= mem_q;
      end
      if (!armed_q) begin
        armed_q <= 1'b1;
        nofs_q  <= empty_ofs;
      end
      rdy_n    <= flag_d;
      aempty_n <= ae_d;
    end
  end

  assign raddr = rptr_q[AW-1:0];
endmodule

// File: rtl/twin_clock_queue.sv
module twin_clock_queue #(
  parameter int WIDTH       = 18,
  parameter int ADDR_W      = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              fwft_mode,
  input  logic              wr_en,
  input  logic [WIDTH-1:0]  wr_data,
  input  logic [ADDR_W:0]   full_ofs,
  input  logic              rd_en,
  input  logic [ADDR_W:0]   empty_ofs,
  output logic [WIDTH-1:0]  rd_data,
  output logic              rdy_n,
  output logic              afull_n,
  output logic              aempty_n,
  output logic              hfull_n
);
  localparam int PW    = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;

  logic              wsrst_n, rsrst_n, wr_fire;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wgray_s, rgray_s, w_used;
  logic [WIDTH-1:0]  mem_q;
  logic [WIDTH-1:0]  mem [DEPTH];

  tcq_rst_sync #(.STAGES(SYNC_STAGES)) u_wrst (.clk(wclk), .arst_n(rst_n), .srst_n(wsrst_n));
  tcq_rst_sync #(.STAGES(SYNC_STAGES)) u_rrst (.clk(rclk), .arst_n(rst_n), .srst_n(rsrst_n));

  tcq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wclk), .rst_n(wsrst_n), .d(rgray), .q(rgray_s));
  tcq_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rclk), .rst_n(rsrst_n), .d(wgray), .q(wgray_s));

  tcq_wside #(.AW(ADDR_W), .PW(PW)) u_wside (
    .wclk(wclk), .srst_n(wsrst_n), .wr_en(wr_en), .rgray_s(rgray_s),
    .full_ofs(full_ofs), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .used(w_used), .afull_n(afull_n), .hfull_n(hfull_n));

  tcq_rside #(.AW(ADDR_W), .PW(PW), .W(WIDTH)) u_rside (
    .rclk(rclk), .srst_n(rsrst_n), .fwft(fwft_mode), .rd_en(rd_en),
    .wgray_s(wgray_s), .empty_ofs(empty_ofs), .mem_q(mem_q), .raddr(raddr),
    .rgray(rgray), .rd_data(rd_data), .rdy_n(rdy_n), .aempty_n(aempty_n));

  // storage: written on wclk, read combinationally at the read pointer
  always_ff @(posedge wclk) begin
    if (wr_fire) mem[waddr] <= wr_data;
  end

  assign mem_q = mem[raddr];
endmodule

// File: rtl/tcq_check.sv
module tcq_check #(
  parameter int WIDTH  = 18,
  parameter int ADDR_W = 5
) (
  input logic              wclk,
  input logic              rclk,
  input logic              rst_n,
  input logic              fwft_mode,
  input logic              wr_en,
  input logic              rd_en,
  input logic [WIDTH-1:0]  rd_data,
  input logic              rdy_n,
  input logic              afull_n,
  input logic              aempty_n,
  input logic              hfull_n,
  input logic [ADDR_W:0]   w_used
);
  localparam logic [ADDR_W:0] DEPTH_V = (ADDR_W+1)'(1 << ADDR_W);

  // R2: standard-mode read on empty leaves the output untouched
  assert_empty_read_ignored_R2: assert property (@(posedge rclk) disable iff (!rst_n)
    (!fwft_mode && !rdy_n && rd_en) |=> $stable(rd_data));

  // R3: presented word stays until a read consumes it
  assert_ready_word_held_R3: assert property (@(posedge rclk) disable iff (!rst_n)
    (fwft_mode && !rdy_n && !rd_en) |=> (!rdy_n && $stable(rd_data)));

  // R4: almost-full cannot newly assert without a write
  assert_afull_needs_write_R4: assert property (@(posedge wclk) disable iff (!rst_n)
    (afull_n && !wr_en) |=> afull_n);

  // R5: almost-empty cannot newly assert without a read
  assert_aempty_needs_read_R5: assert property (@(posedge rclk) disable iff (!rst_n)
    (aempty_n && !rd_en) |=> aempty_n);

  // R6: half-full is only set by a write
  assert_hfull_needs_write_R6: assert property (@(posedge wclk) disable iff (!rst_n)
    (hfull_n && !wr_en) |=> hfull_n);

  // R7: memory occupancy never passes the depth
  assert_no_overflow_R7: assert property (@(posedge wclk) disable iff (!rst_n)
    w_used <= DEPTH_V);
endmodule

bind twin_clock_queue tcq_check #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_check (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .rdy_n(rdy_n),
  .afull_n(afull_n), .aempty_n(aempty_n), .hfull_n(hfull_n), .w_used(w_used));

// File: tb/twin_clock_queue_test.sv
module twin_clock_queue_test;
  localparam int AW = 5;
  localparam int D  = 1 << AW;
  localparam int W  = 18;

  logic          wclk, rclk, rst_n, fwft_mode, wr_en, rd_en;
  logic [W-1:0]  wr_data, rd_data;
  logic [AW:0]   full_ofs, empty_ofs;
  logic          rdy_n, afull_n, aempty_n, hfull_n;

  int total, bad, cnt, m_c, n_c;
  int q[$];
  int last;

  twin_clock_queue #(.WIDTH(W), .ADDR_W(AW)) uut (
    .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_mode(fwft_mode),
    .wr_en(wr_en), .wr_data(wr_data), .full_ofs(full_ofs), .rd_en(rd_en),
    .empty_ofs(empty_ofs), .rd_data(rd_data), .rdy_n(rdy_n),
    .afull_n(afull_n), .aempty_n(aempty_n), .hfull_n(hfull_n));

  initial wclk = 1'b0;
  always #10 wclk = ~wclk;
  initial rclk = 1'b0;
  always #13 rclk = ~rclk;

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge wclk);
    repeat (8) @(negedge rclk);
  endtask

  function automatic int cap();
    return fwft_mode ? D + 1 : D;
  endfunction

  task automatic check_flags(input string ctx);
    if (!fwft_mode) begin
      check({"R2 empty flag ", ctx}, rdy_n, (cnt > 0) ? 1 : 0);
      check({"R4 afull ", ctx}, afull_n, (cnt >= D - m_c) ? 0 : 1);
      check({"R6 hfull ", ctx}, hfull_n, (cnt > D / 2) ? 0 : 1);
      check({"R5 aempty ", ctx}, aempty_n, (cnt <= n_c) ? 0 : 1);
    end else begin
      check({"R3 ready flag ", ctx}, rdy_n, (cnt == 0) ? 1 : 0);
      check({"R4 afull ", ctx}, afull_n, (cnt >= D + 1 - m_c) ? 0 : 1);
      check({"R6 hfull ", ctx}, hfull_n, (cnt >= D / 2 + 2) ? 0 : 1);
      check({"R5 aempty ", ctx}, aempty_n, (cnt <= n_c + 1) ? 0 : 1);
      if (cnt > 0) check({"R3 head word ", ctx}, int'(rd_data), q[0]);
    end
  endtask

  // reset with a given mode and offsets, then scramble the offset pins (R9)
  task automatic do_reset(input logic mode, input int m, input int n);
    @(negedge wclk);
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    fwft_mode = mode;
    full_ofs  = (AW+1)'(m);
    empty_ofs = (AW+1)'(n);
    m_c = m; n_c = n; cnt = 0; q.delete();
    repeat (4) @(negedge rclk);
    check("R8 reset rdy_n", rdy_n, 1);
    check("R8 reset aempty_n", aempty_n, 0);
    check("R8 reset afull_n", afull_n, 1);
    check("R8 reset hfull_n", hfull_n, 1);
    @(negedge wclk);
    rst_n = 1'b1;
    settle();
    check("R8 flag after release", rdy_n, mode ? 1 : 0);
    full_ofs  = (AW+1)'(m + 7);
    empty_ofs = (AW+1)'(n + 6);
  endtask

  task automatic write_word(input int val);
    @(negedge wclk);
    wr_en = 1'b1; wr_data = W'(val);
    @(negedge wclk);
    wr_en = 1'b0;
    if (cnt < cap()) begin
      q.push_back(val);
      cnt++;
    end
  endtask

  task automatic read_pulse();
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  // fill past capacity and drain in standard mode
  task automatic t_std_fill_drain();
    do_reset(1'b0, 3, 2);
    check_flags("empty");
    for (int k = 1; k <= D + 2; k++) begin
      write_word(18'h1000 + k);
      settle();
      check_flags($sformatf("std fill %0d", k));
    end
    check("R7 std capacity", cnt, D);
    for (int k = 0; k < D; k++) begin
      read_pulse();
      last = q.pop_front();
      cnt--;
      check("R1 std read order", int'(rd_data), last);
      settle();
      check_flags($sformatf("std drain %0d", k));
    end
    read_pulse();
    check("R2 read on empty holds data", int'(rd_data), last);
    settle();
    check("R2 still empty", rdy_n, 0);
  endtask

  // fill past capacity and drain in fall-through mode
  task automatic t_fwft_fill_drain();
    do_reset(1'b1, 4, 3);
    check_flags("empty");
    for (int k = 1; k <= D + 3; k++) begin
      write_word(18'h2000 + k);
      settle();
      check_flags($sformatf("fwft fill %0d", k));
    end
    check("R7 fwft capacity", cnt, D + 1);
    for (int k = 0; k < D + 1; k++) begin
      read_pulse();
      last = q.pop_front();
      cnt--;
      settle();
      check_flags($sformatf("fwft drain %0d", k));
    end
    check("R3 last word kept", int'(rd_data), last);
    read_pulse();
    settle();
    check("R3 extra read ignored data", int'(rd_data), last);
    check("R3 extra read ignored flag", rdy_n, 1);
  endtask

  // concurrent writer and reader on both clocks
  task automatic t_stream(input logic mode);
    int sq[$];
    int got;
    int guard;
    do_reset(mode, 2, 2);
    got = 0;
    guard = 0;
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          @(negedge wclk);
          wr_en = 1'b1; wr_data = W'(18'h3000 + i * 5);
          sq.push_back(18'h3000 + i * 5);
          @(negedge wclk);
          wr_en = 1'b0;
        end
      end
      begin
        while (got < 40 && guard < 4000) begin
          @(negedge rclk);
          guard++;
          if (mode) begin
            if (!rdy_n) begin
              check("R1 stream order fwft", int'(rd_data), sq.pop_front());
              got++;
              rd_en = 1'b1;
            end else rd_en = 1'b0;
          end else begin
            if (rd_en) begin
              check("R1 stream order std", int'(rd_data), sq.pop_front());
              got++;
            end
            rd_en = (got < 40) ? rdy_n : 1'b0;
          end
        end
        @(negedge rclk);
        rd_en = 1'b0;
      end
    join
    check("R1 stream word count", got, 40);
    settle();
    check("R1 stream ends empty", rdy_n, mode ? 1 : 0);
    check("R5 stream ends almost empty", aempty_n, 0);
    check("R6 stream ends below half", hfull_n, 1);
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; fwft_mode = 1'b0;
    wr_data = '0; full_ofs = '0; empty_ofs = '0;
    t_std_fill_drain();
    t_fwft_fill_drain();
    t_stream(1'b1);
    t_stream(1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge wclk);
    total++; bad++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule